// File: doc/BRIEF.md
# Depopulated Configurable Logic Cluster

This block is a programmable logic cluster of K logic elements (K = 8 by default). Each element holds a 4-input lookup table whose result can be taken straight through or through a flip-flop. The table inputs are not fed by a full crossbar over every cluster input and every element output. They are fed by a two-stage local network. First an upward K-by-K crossbar picks among the element outputs. Then four small downward crossbars, one per table input pin, each choose from a quarter of the cluster inputs plus a quarter of the upward outputs. Downward crossbar j drives pin j of every element. The upward outputs are also the cluster outputs, so any element result can leave the cluster or return to any element.

All table contents, mode bits and selector indices sit in one serial configuration chain. The chain is loaded one bit per clock while the load enable is high. During loading the cluster stays quiet: every element output reads zero and every flip-flop is held clear. User logic starts on the first clock after the enable falls. A configuration output at the far end of the chain lets several clusters be chained.

Top module: `lc_cluster`

## Requirements
- R1: While cfg_en is high, each rising clock moves every chain bit one place toward the higher index and loads cfg_din into bit 0. While cfg_en is low, the chain holds. cfg_dout always shows the highest chain bit. The default chain is 288 bits long.
- R2: While cfg_en is high, cl_out is all zero and every flip-flop is cleared. After cfg_en falls, a registered element reads 0 until its first capture edge.
- R3: rst is synchronous. It clears every element flip-flop and leaves the configuration unchanged.
- R4: An element in combinational mode (mode bit 0) outputs bit number {pin3,pin2,pin1,pin0} of its 16-bit table, with pin0 as the least significant index bit.
- R5: An element in registered mode (mode bit 1) outputs the table value present at the previous rising clock.
- R6: cl_out[o] equals the output of the element whose number is the 3-bit upward index of output o.
- R7: Downward index values 0 to NIN/4-1 on crossbar j select cluster input cl_in[j*NIN/4 + index] for pin j of the element.
- R8: Downward index values NIN/4 to NIN/4+K/4-1 on crossbar j select upward output number j*K/4 + (index - NIN/4). This is the feedback path.
- R9: A downward index of NIN/4+K/4 or above (10 to 15 by default) drives that pin to 0.
- R10: The chain layout, counted from bit 0, is as follows. For each element e there are 17 bits at e*17: the table in the low 16 bits, then the mode bit. Next come the upward indices, 3 bits per output, at 136 + o*3. Last come the downward indices, 4 bits each, at 160 + (j*8 + e)*4 for pin j of element e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous clear of the element flip-flops |
| cfg_en | input | 1 | Configuration load enable; shifts the chain and quiets the cluster |
| cfg_din | input | 1 | Serial configuration bit entering chain bit 0 |
| cfg_dout | output | 1 | Highest chain bit, for chaining clusters |
| cl_in | input | NIN (32) | Cluster inputs |
| cl_out | output | K (8) | Cluster outputs, equal to the upward crossbar outputs |

## Verification
The embedded assertions watch, on every cycle:
- the chain shifting when loading is enabled and holding when it is not;
- the flip-flops clearing during loading and capturing the table value one edge later;
- each selector decode staying one-hot or empty, with an out-of-range index giving zero;
- the cluster outputs staying zero while loading.

Only the bench scenarios can show the rest:
- the table function;
- the mapping of each downward index to a specific cluster input or upward output;
- the feedback loop through the upward crossbar;
- reset in the middle of operation, with the configuration kept.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LUT_IN = 4;
  localparam int LUT_SZ = 1 << LUT_IN;
  localparam int LE_CFG = LUT_SZ + 1;

  // width of a binary selector index for n candidates
  function automatic int sel_w(input int n);
    if (n <= 2) return 1;
    return $clog2(n);
  endfunction

  // first chain bit of the upward index block
  function automatic int up_base(input int k);
    return k * LE_CFG;
  endfunction

  // first chain bit of the downward index block
  function automatic int dn_base(input int k, input int uw);
    return k * LE_CFG + k * uw;
  endfunction

  // total chain length
  function automatic int cfg_len(input int k, input int uw, input int dw);
    return dn_base(k, uw) + LUT_IN * k * dw;
  endfunction
endpackage

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
  parameter int LEN = 288
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_en,
  input  logic           cfg_din,
  output logic [LEN-1:0] cfg_q,
  output logic           cfg_dout
);
  // configuration storage is not reset: it survives a user reset
  always_ff @(posedge clk) begin
    if (cfg_en) cfg_q <= {cfg_q[LEN-2:0], cfg_din};
  end

  assign cfg_dout = cfg_q[LEN-1];

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_q));
  p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg_q[0] == $past(cfg_din));
  p_shift_move_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg_q[LEN-1:1] == $past(cfg_q[LEN-2:0]));
endmodule

// File: rtl/lc_sel.sv
module lc_sel #(
  parameter int N = 10,
  parameter int W = 4
) (
  input  logic [W-1:0] sel,
  input  logic [N-1:0] d,
  output logic         y
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hit[i] = (sel == W'(i));
  end

  assign y = |(hit & d);

  always_comb begin
    p_onehot_sel_r7: assert ($onehot0(hit));
    if ({1'b0, sel} >= (W+1)'(N)) begin
      p_oor_zero_r9: assert (y == 1'b0);
    end
  end
endmodule

// File: rtl/lc_le.sv
module lc_le
  import lc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic [LUT_SZ-1:0] lut_cfg,
  input  logic              reg_mode,
  input  logic [LUT_IN-1:0] pins,
  output logic              le_out
);
  logic lut_val;
  logic ff_q;

  assign lut_val = lut_cfg[pins];

  always_ff @(posedge clk) begin
    if (rst || cfg_en) ff_q <= 1'b0;
    else               ff_q <= lut_val;
  end

  // forced quiet during loading: breaks any loop a half-loaded chain could form
  assign le_out = cfg_en ? 1'b0 : (reg_mode ? ff_q : lut_val);

  p_cfg_clear_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> !ff_q);
  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> ff_q == $past(lut_val));
endmodule

// File: rtl/lc_cluster.sv
module lc_cluster
  import lc_pkg::*;
#(
  parameter int K   = 8,
  parameter int NIN = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_en,
  input  logic           cfg_din,
  output logic           cfg_dout,
  input  logic [NIN-1:0] cl_in,
  output logic [K-1:0]   cl_out
);
  localparam int DN_EXT = NIN / LUT_IN;
  localparam int DN_FB  = K / LUT_IN;
  localparam int DN_N   = DN_EXT + DN_FB;
  localparam int UW     = sel_w(K);
  localparam int DW     = sel_w(DN_N);
  localparam int UP_B   = up_base(K);
  localparam int DN_B   = dn_base(K, UW);
  localparam int CFG_N  = cfg_len(K, UW, DW);

  logic [CFG_N-1:0]             cfg_q;
  logic [K-1:0]                 le_out;
  logic [K-1:0]                 up_out;
  logic [LUT_IN-1:0][DN_N-1:0]  dn_in;
  logic [LUT_IN-1:0][K-1:0]     dn_y;
  logic [K-1:0][LUT_IN-1:0]     pins;

  lc_cfg_chain #(.LEN(CFG_N)) chain_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_q(cfg_q), .cfg_dout(cfg_dout)
  );

  // logic elements
  for (genvar e = 0; e < K; e++) begin : g_le
    for (genvar j = 0; j < LUT_IN; j++) begin : g_pin
      assign pins[e][j] = dn_y[j][e];
    end
    lc_le le_i (
      .clk(clk), .rst(rst), .cfg_en(cfg_en),
      .lut_cfg(cfg_q[e*LE_CFG +: LUT_SZ]),
      .reg_mode(cfg_q[e*LE_CFG + LUT_SZ]),
      .pins(pins[e]),
      .le_out(le_out[e])
    );
  end

  // upward full crossbar over element outputs
  for (genvar o = 0; o < K; o++) begin : g_up
    lc_sel #(.N(K), .W(UW)) up_i (
      .sel(cfg_q[UP_B + o*UW +: UW]),
      .d(le_out),
      .y(up_out[o])
    );
  end

  // downward mini-crossbars, one per table input pin
  for (genvar j = 0; j < LUT_IN; j++) begin : g_dn
    assign dn_in[j] = {up_out[j*DN_FB +: DN_FB], cl_in[j*DN_EXT +: DN_EXT]};
    for (genvar e = 0; e < K; e++) begin : g_out
      lc_sel #(.N(DN_N), .W(DW)) dn_i (
        .sel(cfg_q[DN_B + (j*K + e)*DW +: DW]),
        .d(dn_in[j]),
        .y(dn_y[j][e])
      );
    end
  end

  assign cl_out = up_out;

  p_quiet_cfg_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> cl_out == '0);
endmodule

// File: tb/lc_cluster_tb_top.sv
`timescale 1ns/1ps
module lc_cluster_tb_top;
  localparam int K = 8;
  localparam int NIN = 32;
  localparam int UPB = 136;
  localparam int DNB = 160;
  localparam int CFG_N = 288;

  logic clk = 1'b0;
  logic rst, cfg_en, cfg_din;
  logic cfg_dout;
  logic [NIN-1:0] cl_in;
  logic [K-1:0] cl_out;

  always #2.5 clk = ~clk;

  lc_cluster dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .cl_in(cl_in), .cl_out(cl_out)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [15:0] luts [K];
  bit          regm [K];
  int          usel [K];
  int          dsel [4][K];
  logic [CFG_N-1:0] cv, prev;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R10 layout
  task automatic build_cv();
    cv = '0;
    for (int e = 0; e < K; e++) begin
      cv[e*17 +: 16] = luts[e];
      cv[e*17 + 16]  = regm[e];
    end
    for (int o = 0; o < K; o++) cv[UPB + o*3 +: 3] = 3'(usel[o]);
    for (int j = 0; j < 4; j++)
      for (int e = 0; e < K; e++) cv[DNB + (j*K + e)*4 +: 4] = 4'(dsel[j][e]);
  endtask

  task automatic load(input bit chk_dout);
    build_cv();
    cfg_en = 1'b1;
    for (int i = 0; i < CFG_N; i++) begin
      #1;
      if (chk_dout && i < 12) chk(cfg_dout == prev[CFG_N-1-i], "R1 dout during shift", 32'(cfg_dout), 32'(prev[CFG_N-1-i]));
      if (i == 100) begin
        cl_in = '1;
        #1;
        chk(cl_out == '0, "R2 quiet while loading", 32'(cl_out), 32'h0);
      end
      cfg_din = cv[CFG_N-1-i];
      @(negedge clk);
    end
    cl_in = '0;
    cfg_en = 1'b0;
    prev = cv;
  endtask

  // comb-mode model from the requirements, no feedback selections
  function automatic logic [K-1:0] model(input logic [NIN-1:0] ci);
    logic [K-1:0] le;
    logic [K-1:0] r;
    for (int e = 0; e < K; e++) begin
      logic [3:0] p;
      for (int j = 0; j < 4; j++) begin
        int s;
        s = dsel[j][e];
        p[j] = (s < 8) ? ci[j*8 + s] : 1'b0; // R7, R9
      end
      le[e] = luts[e][p]; // R4
    end
    for (int o = 0; o < K; o++) r[o] = le[usel[o]]; // R6
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    logic [4:0] old5;
    logic [2:0] low;
    rst = 1'b1; cfg_en = 1'b1; cfg_din = 1'b0; cl_in = '1;
    prev = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(cl_out == '0, "R3 reset state", 32'(cl_out), 32'h0);
    rst = 1'b0;

    // config A: combinational, external inputs only, permuted upward
    for (int e = 0; e < K; e++) begin
      luts[e] = 16'h6A5C ^ 16'(e * 16'h2493);
      regm[e] = 1'b0;
      usel[e] = (e*3 + 1) % 8;
      for (int j = 0; j < 4; j++) dsel[j][e] = (e + 3*j) % 8;
    end
    load(1'b0);
    #1;
    for (int i = 0; i < 5; i++) begin
      cfg_din = ~cfg_din;
      @(negedge clk); #1;
      chk(cfg_dout == cv[CFG_N-1], "R1 hold with enable low", 32'(cfg_dout), 32'(cv[CFG_N-1]));
    end
    x = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      cl_in = x;
      #1;
      // R4 R6 R7
      chk(cl_out == model(x), "R4 R6 R7 comb sweep", 32'(cl_out), 32'(model(x)));
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      @(negedge clk);
    end

    // config C: out-of-range downward indices on pin1
    for (int e = 0; e < K; e++) begin
      luts[e] = (e % 2 == 0) ? 16'h3333 : 16'hCCCC;
      regm[e] = 1'b0;
      usel[e] = e;
      for (int j = 0; j < 4; j++) dsel[j][e] = e;
      dsel[1][e] = 10 + (e % 6);
    end
    load(1'b1);
    cl_in = '1;
    #1;
    chk(cl_out == 8'h55, "R9 out-of-range pin reads zero", 32'(cl_out), 32'h55);
    x = 32'h0BAD_F00D;
    for (int i = 0; i < 64; i++) begin
      cl_in = x;
      #1;
      chk(cl_out == model(x), "R9 sweep", 32'(cl_out), 32'(model(x)));
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      @(negedge clk);
    end

    // config B: registered, feedback toggle and capture
    for (int e = 0; e < K; e++) begin
      luts[e] = 16'hAAAA;
      regm[e] = 1'b1;
      usel[e] = e;
      for (int j = 0; j < 4; j++) dsel[j][e] = 15;
      dsel[0][e] = e;
    end
    luts[0] = 16'h5555;
    dsel[0][0] = 8;  // up_out[0]
    dsel[0][1] = 9;  // up_out[1]
    usel[0] = 0; usel[1] = 0; usel[2] = 1;
    load(1'b1);
    #1;
    chk(cl_out == '0, "R2 flops clear after load", 32'(cl_out), 32'h0);
    for (int t = 1; t <= 7; t++) begin
      logic l0, l1;
      @(negedge clk); #1;
      l0 = t[0];
      l1 = ~t[0];
      // R8 feedback through upward outputs, R5 one-edge latency
      chk(cl_out == {5'b0, l1, l0, l0}, "R8 R5 feedback toggle", 32'(cl_out), 32'({5'b0, l1, l0, l0}));
    end
    rst = 1'b1;
    @(negedge clk); #1;
    chk(cl_out == '0, "R3 mid-run reset", 32'(cl_out), 32'h0);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(cl_out == 8'b0000_0011, "R3 config kept after reset", 32'(cl_out), 32'h3);
    old5 = 5'b0;
    for (int v = 1; v < 32; v++) begin
      cl_in[7:3] = 5'(v);
      #1;
      chk(cl_out[7:3] == old5, "R5 before capture edge", 32'(cl_out[7:3]), 32'(old5));
      @(negedge clk); #1;
      chk(cl_out[7:3] == 5'(v), "R5 after capture edge", 32'(cl_out[7:3]), 32'(v));
      old5 = 5'(v);
    end
    low = cl_out[2:0];
    chk(low == 3'b011 || low == 3'b100, "R8 toggle still running", 32'(low), 32'h3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule